// File: doc/BRIEF.md
# Indirect Wide-RAM Access Controller

This block lets a 64-bit register bus reach an internal RAM whose words are wider than the bus: 133 bits by default. A bank of 64-bit staging registers holds one full RAM word, split across as many bus words as needed. Software fills or drains the staging bank with ordinary register accesses. It then writes a command register that names a RAM address and an operation. The operation is one of: load the RAM word into the staging bank, store the staging bank into the RAM word, or XOR the staging bank into the stored word in place.

A small sequencer runs each operation against a RAM with one cycle of read latency and raises a busy flag while it works. The staging bank is frozen while busy, and a second command issued during an operation is dropped. Software can therefore poll the busy flag and then read a consistent result.

Top module: `wram_indirect_ctrl`

## Requirements
- R1: A read command (opcode 01) copies the addressed RAM word into the staging registers.
- R2: A write command (opcode 10) copies the staging registers into the addressed RAM word.
- R3: A read-modify-write command (opcode 11) replaces the addressed RAM word with its old value XOR the staging registers.
- R4: Staging register k, at bus index k, holds RAM word bits 64k+63 down to 64k. With 133-bit words, index 2 holds bits 132:128 in its bits 4:0.
- R5: Staging bits above the RAM width read back as zero and never reach the RAM, whatever value is written to them.
- R6: After reset, every staging register reads zero and the busy flag is clear.
- R7: Staging registers respond only to accesses with both secure and privileged asserted. Other writes leave them unchanged, and other reads return zero.
- R8: The command register sits at bus index 7. Bits 1:0 are the opcode and bits 11:8 are the RAM address. Reading it returns busy in bit 31. Opcode 00 starts nothing.
- R9: Busy is set on the clock edge that accepts a command. It stays set for one cycle for a write and for two cycles for a read or a read-modify-write.
- R10: A command written while busy is ignored.
- R11: Staging-register writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register index: 0..2 staging, 7 command |
| bus_wdata | input | 64 | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 64 | Read data, combinational from index |

## Verification
Every RAM address is first written with a distinct address-derived word and then read back into a cleared staging bank. This separates address decoding faults from slice-placement faults across the three staging registers. A second sweep XORs an address-derived operand into every word. The operand sets all unused high bits, so a correct XOR can be told apart from an overwrite and from leakage of the unused bits. Separate patterns issue a command or a staging write in the cycle right after a command, and make accesses with the secure or privileged qualifier missing. These patterns distinguish the busy interlock and the access gating from normal operation.

// File: rtl/wri_pkg.sv
// Shared types for the indirect wide-RAM controller.
// Assumes: opcode encoding is fixed by the command register layout.
package wri_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RMW   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDREQ,
        ST_RDCAP,
        ST_WRITE
    } st_e;
endpackage

// File: rtl/wri_ram.sv
// Single-port storage for wide words with one cycle of read latency.
// Assumes: read and write are never requested in the same cycle; contents are not reset.
module wri_ram #(
    parameter int DATA_W = 133,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word when a write is requested.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end

    // Register the read word one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (re) dout <= mem[addr];
    end
endmodule

// File: rtl/wri_seq.sv
// Operation sequencer: accepts a command when idle and drives RAM strobes.
// Read and read-modify-write take a request cycle then a capture cycle;
// write takes one cycle. Commands arriving while busy are dropped.
module wri_seq #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr,
    input  logic [1:0]        trig_op,
    input  logic [ADDR_W-1:0] trig_addr,
    output logic              busy,
    output logic              ram_re,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              wr_xor,
    output logic              load_content
);
    import wri_pkg::*;

    st_e               state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    op_e               op_in;

    assign op_in = op_e'(trig_op);

    // Advance the operation state and latch a command accepted when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (trig_wr && op_in != OP_NONE) begin
                    op_q   <= op_in;
                    addr_q <= trig_addr;
                    state  <= (op_in == OP_WRITE) ? ST_WRITE : ST_RDREQ;
                end
                ST_RDREQ: state <= ST_RDCAP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Decode RAM strobes and bank controls from the current state.
    always_comb begin
        busy         = (state != ST_IDLE);
        ram_re       = (state == ST_RDREQ);
        ram_we       = (state == ST_WRITE) || (state == ST_RDCAP && op_q == OP_RMW);
        wr_xor       = (state == ST_RDCAP);
        load_content = (state == ST_RDCAP) && (op_q == OP_READ);
        ram_addr     = addr_q;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |=> !busy); // R9
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && !wr_xor |=> !busy); // R9
    AST_TRIG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trig_wr |=> $stable(addr_q) && $stable(op_q)); // R10
endmodule

// File: rtl/wri_regs.sv
// Staging bank: NREG bus-wide registers holding one RAM word, plus read mux.
// Assumes: acc_ok already combines the security qualifiers; load_en only
// occurs while busy, so it never collides with an accepted bus write.
module wri_regs #(
    parameter int DATA_W = 133,
    parameter int BUS_W  = 64,
    parameter int IDX_W  = 3,
    parameter int NREG   = (DATA_W + BUS_W - 1) / BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ok,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              busy,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] content,
    output logic [BUS_W-1:0]  rd_word
);
    localparam int PAD_W = NREG * BUS_W;
    localparam logic [PAD_W-1:0] VALID = PAD_W'({DATA_W{1'b1}});

    logic [PAD_W-1:0] pad;
    logic [PAD_W-1:0] load_pad;

    assign load_pad = PAD_W'(load_data);
    assign content  = pad[DATA_W-1:0];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Load slice k from the RAM or from an accepted, idle bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pad[k*BUS_W +: BUS_W] <= '0;
            else if (load_en)
                pad[k*BUS_W +: BUS_W] <= load_pad[k*BUS_W +: BUS_W];
            else if (wr_en && acc_ok && !busy && idx == IDX_W'(k))
                pad[k*BUS_W +: BUS_W] <= wdata & VALID[k*BUS_W +: BUS_W];
        end
    end

    // Return the selected slice to an allowed reader, zero otherwise.
    always_comb begin
        rd_word = '0;
        if (rd_en && acc_ok && idx < IDX_W'(NREG))
            rd_word = pad[32'(idx) * BUS_W +: BUS_W];
    end

    if (PAD_W > DATA_W) begin : g_chk_pad
        AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            pad[PAD_W-1:DATA_W] == '0); // R5
    end
    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load_en |=> $stable(pad)); // R11
    AST_SECURE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !acc_ok && !load_en |=> $stable(pad)); // R7
endmodule

// File: rtl/wram_indirect_ctrl.sv
// Top: register decode, staging bank, sequencer and wide RAM.
// Index 0..NREG-1 are staging registers, index 2**IDX_W-1 is the command
// register. Command fields: opcode in bits 1:0, RAM address from bit 8.
module wram_indirect_ctrl #(
    parameter int DATA_W = 133,
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 64,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_secure,
    input  logic             bus_priv,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int NREG     = (DATA_W + BUS_W - 1) / BUS_W;
    localparam int CMD_IDX  = (1 << IDX_W) - 1;
    localparam int ADDR_LSB = 8;
    localparam int BUSY_BIT = 31;

    logic              acc_ok, wr_en, rd_en, trig_wr;
    logic              busy, ram_re, ram_we, wr_xor, load_content;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_din, ram_dout, content;
    logic [BUS_W-1:0]  reg_word;

    assign acc_ok  = bus_secure && bus_priv;
    assign wr_en   = bus_req && bus_we;
    assign rd_en   = bus_req && !bus_we;
    assign trig_wr = wr_en && (bus_idx == IDX_W'(CMD_IDX));
    assign ram_din = wr_xor ? (ram_dout ^ content) : content;

    // Select read data: busy flag for the command index, else the bank slice.
    always_comb begin
        if (rd_en && bus_idx == IDX_W'(CMD_IDX))
            bus_rdata = BUS_W'(busy) << BUSY_BIT;
        else
            bus_rdata = reg_word;
    end

    wri_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .wr_en(wr_en), .rd_en(rd_en),
        .idx(bus_idx), .wdata(bus_wdata), .busy(busy), .load_en(load_content),
        .load_data(ram_dout), .content(content), .rd_word(reg_word)
    );

    wri_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_op(bus_wdata[1:0]),
        .trig_addr(bus_wdata[ADDR_LSB +: ADDR_W]), .busy(busy), .ram_re(ram_re),
        .ram_we(ram_we), .ram_addr(ram_addr), .wr_xor(wr_xor),
        .load_content(load_content)
    );

    wri_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .re(ram_re), .we(ram_we), .addr(ram_addr),
        .din(ram_din), .dout(ram_dout)
    );

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_content |=> content == $past(ram_dout)); // R1
    AST_RAM_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_we && !ram_re); // R2
endmodule

// File: tb/wram_indirect_ctrl_test.sv
`timescale 1ns/1ps
module wram_indirect_ctrl_test;
    localparam int DW = 133;
    localparam int AW = 4;
    localparam int NA = 1 << AW;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_req = 0, bus_we = 0, bus_secure = 1, bus_priv = 1;
    logic [2:0]  bus_idx = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] mdl [NA];

    always #4 clk = ~clk;

    wram_indirect_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_priv(bus_priv), .bus_rdata(bus_rdata)
    );

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        logic [63:0] lo, mid;
        logic [4:0]  hi;
        lo  = 64'h9E3779B97F4A7C15 * 64'(a + 1) ^ 64'(seed * 32'h01234567);
        mid = 64'hC2B2AE3D27D4EB4F * 64'(a + 3 + seed);
        hi  = 5'(a * 7 + seed + 1);
        return {hi, mid, lo};
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [63:0] d, input bit sec = 1, input bit prv = 1);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_idx = 3'(idx); bus_wdata = d;
        bus_secure = sec; bus_priv = prv;
        @(posedge clk); #1;
        bus_req = 0; bus_we = 0; bus_secure = 1; bus_priv = 1;
    endtask

    task automatic rd(input int idx, output logic [63:0] d, input bit sec = 1, input bit prv = 1);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_idx = 3'(idx); bus_secure = sec; bus_priv = prv;
        #1 d = bus_rdata;
        bus_req = 0; bus_secure = 1; bus_priv = 1;
    endtask

    task automatic cmd(input int op, input int a);
        wr(7, 64'(op) | (64'(a) << 8));
    endtask

    task automatic wait_idle();
        logic [63:0] s;
        for (int i = 0; i < 20; i++) begin
            rd(7, s);
            if (!s[31]) return;
        end
        check(s, 64'h0, "R9 busy stuck");
    endtask

    task automatic load_bank(input logic [DW-1:0] w, input logic [63:0] top_extra);
        wr(0, w[63:0]);
        wr(1, w[127:64]);
        wr(2, 64'(w[132:128]) | top_extra);
    endtask

    task automatic cmp_bank(input logic [DW-1:0] w, input string tag);
        logic [63:0] d;
        rd(0, d); check(d, w[63:0], tag);
        rd(1, d); check(d, w[127:64], tag);
        rd(2, d); check(d, 64'(w[132:128]), tag);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [DW-1:0] x, y;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R6: reset state
        for (int k = 0; k < 3; k++) begin rd(k, d); check(d, 64'h0, "R6 bank reset"); end
        rd(7, d); check(d, 64'h0, "R6 busy reset");

        // R5/R4: unused bits of index 2 read zero
        wr(2, '1); rd(2, d); check(d, 64'h1F, "R5 unused bits");

        // R2/R9: write every address
        for (int a = 0; a < NA; a++) begin
            mdl[a] = pat(a, 0);
            load_bank(mdl[a], 64'h0);
            cmd(2, a);
            if (a == 0) begin
                rd(7, d); check(d, 64'h8000_0000, "R9 write busy");
                rd(7, d); check(d, 64'h0, "R9 write done");
            end else wait_idle();
        end

        // R1/R4: read every address into a cleared bank
        for (int a = 0; a < NA; a++) begin
            load_bank('0, 64'h0);
            cmd(1, a);
            if (a == 0) begin
                rd(7, d); check(d, 64'h8000_0000, "R9 read busy1");
                rd(7, d); check(d, 64'h8000_0000, "R9 read busy2");
                rd(7, d); check(d, 64'h0, "R9 read done");
            end else wait_idle();
            cmp_bank(mdl[a], "R1 R2 R4 readback");
        end

        // R3/R5: XOR every address, unused high bits set in the operand
        for (int a = 0; a < NA; a++) begin
            x = pat(a, 5);
            load_bank(x, 64'hFFFF_FFFF_FFFF_FFE0);
            cmd(3, a); wait_idle();
            mdl[a] = mdl[a] ^ x;
        end
        for (int a = 0; a < NA; a++) begin
            cmd(1, a); wait_idle();
            cmp_bank(mdl[a], "R3 R5 rmw result");
        end

        // R10: command during busy is dropped
        load_bank(pat(9, 9), 64'h0);
        cmd(1, 1);
        cmd(2, 2);
        wait_idle();
        cmp_bank(mdl[1], "R10 bank after read");
        cmd(1, 2); wait_idle();
        cmp_bank(mdl[2], "R10 target untouched");

        // R11: bank write during busy is dropped
        y = pat(3, 11);
        load_bank(y, 64'h0);
        cmd(2, 3);
        wr(0, 64'hDEAD_BEEF_0000_0001);
        wait_idle();
        rd(0, d); check(d, y[63:0], "R11 bank frozen");
        mdl[3] = y;
        load_bank('0, 64'h0);
        cmd(1, 3); wait_idle();
        cmp_bank(mdl[3], "R11 ram got operand");

        // R7: security qualifiers
        wr(1, 64'h1111, 1'b0, 1'b1);
        rd(1, d); check(d, mdl[3][127:64], "R7 nonsecure write");
        wr(1, 64'h2222, 1'b1, 1'b0);
        rd(1, d); check(d, mdl[3][127:64], "R7 unprivileged write");
        rd(1, d, 1'b1, 1'b0); check(d, 64'h0, "R7 unprivileged read");
        rd(0, d, 1'b0, 1'b1); check(d, 64'h0, "R7 nonsecure read");

        // R8: opcode 00 starts nothing
        cmd(0, 5);
        rd(7, d); check(d, 64'h0, "R8 null opcode");
        cmp_bank(mdl[3], "R8 bank unchanged");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule